// File: doc/BRIEF.md
# Address-Masked GPIO Data Register

This block holds the output value of a 12-pin general-purpose I/O port and returns the state of those pins on reads. The bus address of each access carries a per-bit enable mask: address bit (i+2) enables data bit i. A single store can therefore set or clear any chosen group of pins without first reading the register. The store is atomic with respect to the other pins.

Reads use the same mask. A bit whose mask bit is clear reads as zero. A bit whose mask bit is set returns the pin input after a two-flop synchronizer. Read data is registered. The word offset 0x3FFC enables all twelve bits, and the offset 0x0000 enables none.

Top module: `masked_gpio_reg`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears `pin_out` and `rd_data` to all zeros.
- R2: When `wr_en` is high at a rising edge, the mask is `bus_addr[13:2]` (mask bit i = `bus_addr[i+2]`). Each `pin_out` bit i with mask bit 1 takes `wr_data[i]`, and each bit with mask bit 0 keeps its value.
- R3: A write at offset 0x0000 has an all-zero mask and leaves `pin_out` unchanged.
- R4: A write at offset 0x3FFC has an all-ones mask and loads all twelve bits of `wr_data`.
- R5: `bus_addr[1:0]` has no effect on the mask of a write or a read.
- R6: When `rd_en` is high at a rising edge, `rd_data` bit i becomes the synchronized pin input bit i if mask bit i is 1, and 0 otherwise. The value is visible after that edge.
- R7: While `rd_en` is low, `rd_data` keeps its last value, whatever happens on `pin_in`, `bus_addr` or the write path.
- R8: `pin_in` passes through two register stages before the read path. After `pin_in` changes, reads captured at the first and second rising edges return the old value, and the read at the third edge returns the new value.
- R9: When `wr_en` is low, `pin_out` does not change, whatever the values on `bus_addr` and `wr_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 14 | Byte address; bits [13:2] form the bit mask |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 12 | Write data |
| rd_data | output | 12 | Registered, masked read data |
| pin_in | input | 12 | Asynchronous pin levels |
| pin_out | output | 12 | Output latch toward the pins |

## Verification
The assertions assume that `bus_addr`, `wr_data`, `wr_en` and `rd_en` are stable around each rising edge. They also assume that `rst_n` is driven to a known level from the first edge. The bench changes every input on the falling edge and holds reset low from time zero. The assertions make no assumption about `pin_in`: it may change at any time. The bench changes it only on falling edges, so the latency of the synchronizer can be counted exactly.

// File: rtl/gpio_mask_pkg.sv
// Shared constants and helpers for the address-masked GPIO register.
// Assumes the byte address is word aligned, so the mask begins at bit MASK_LSB.
package gpio_mask_pkg;
    localparam int MASK_LSB = 2;

    // Merge new data into old data under a bit mask.
    function automatic logic [31:0] merge_bits(input logic [31:0] old_v,
                                               input logic [31:0] new_v,
                                               input logic [31:0] mask);
        return (old_v & ~mask) | (new_v & mask);
    endfunction
endpackage

// File: rtl/gpio_mask_decode.sv
// Derives the per-bit access mask from the upper address bits.
// Assumes the caller has already dropped the byte-offset bits.
module gpio_mask_decode #(
    parameter int WIDTH = 12
) (
    input  logic [WIDTH-1:0] addr_word,
    output logic [WIDTH-1:0] mask
);
    // One mask bit per address bit, same order.
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign mask[i] = addr_word[i];
        end
    endgenerate
endmodule

// File: rtl/gpio_in_sync.sv
// Multi-stage synchronizer for asynchronous pin inputs.
// Assumes STAGES >= 1; the last stage is the only output used.
module gpio_in_sync #(
    parameter int WIDTH  = 12,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stg [STAGES];

    // First stage samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= async_in;
    end

    generate
        for (genvar k = 1; k < STAGES; k++) begin : g_stage
            // Each later stage re-registers the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[k] <= '0;
                else        stg[k] <= stg[k-1];
            end
        end
    endgenerate

    assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/gpio_out_latch.sv
// Output latch with a masked write: only enabled bits take new data.
// Assumes the write strobe and mask are stable at the rising edge.
module gpio_out_latch #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] mask,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] q
);
    logic [31:0] merged;

    // Combine held value and new data under the mask.
    always_comb begin
        merged = gpio_mask_pkg::merge_bits(32'(q), 32'(wr_data), 32'(mask));
    end

    // Latch update on a write, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= merged[WIDTH-1:0];
    end
endmodule

// File: rtl/gpio_read_port.sv
// Registered masked read of the synchronized pin levels.
// Assumes the read strobe is a single-cycle or level request; data holds when idle.
module gpio_read_port #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [WIDTH-1:0] mask,
    input  logic [WIDTH-1:0] pins,
    output logic [WIDTH-1:0] rd_data
);
    // Capture masked pins on a read, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= pins & mask;
    end
endmodule

// File: rtl/masked_gpio_reg.sv
// Address-masked GPIO data register: the word address bits act as a per-bit
// enable for both writes to the output latch and reads of the pin levels.
// Assumes word-aligned accesses; address bits below MASK_LSB are ignored.
module masked_gpio_reg #(
    parameter int WIDTH       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [WIDTH+gpio_mask_pkg::MASK_LSB-1:0] bus_addr,
    input  logic                                   wr_en,
    input  logic                                   rd_en,
    input  logic [WIDTH-1:0]                       wr_data,
    output logic [WIDTH-1:0]                       rd_data,
    input  logic [WIDTH-1:0]                       pin_in,
    output logic [WIDTH-1:0]                       pin_out
);
    localparam int LSB    = gpio_mask_pkg::MASK_LSB;
    localparam int ADDR_W = WIDTH + LSB;

    logic [WIDTH-1:0] acc_mask;
    logic [WIDTH-1:0] pins_sync;
    logic             unused_addr_lsb;

    // Byte-offset bits carry no meaning for this register.
    assign unused_addr_lsb = ^bus_addr[LSB-1:0];

    gpio_mask_decode #(.WIDTH(WIDTH)) u_decode (
        .addr_word (bus_addr[ADDR_W-1:LSB]),
        .mask      (acc_mask)
    );

    gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pins_sync)
    );

    gpio_out_latch #(.WIDTH(WIDTH)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .mask    (acc_mask),
        .wr_data (wr_data),
        .q       (pin_out)
    );

    gpio_read_port #(.WIDTH(WIDTH)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .mask    (acc_mask),
        .pins    (pins_sync),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/masked_gpio_reg_chk.sv
// Port-level property checker for masked_gpio_reg, attached by bind.
// Assumes inputs are stable around each rising edge.
module masked_gpio_reg_chk #(
    parameter int WIDTH = 12
) (
    input logic                                     clk,
    input logic                                     rst_n,
    input logic [WIDTH+gpio_mask_pkg::MASK_LSB-1:0] bus_addr,
    input logic                                     wr_en,
    input logic                                     rd_en,
    input logic [WIDTH-1:0]                         wr_data,
    input logic [WIDTH-1:0]                         rd_data,
    input logic [WIDTH-1:0]                         pin_out
);
    localparam int LSB = gpio_mask_pkg::MASK_LSB;

    logic             armed = 1'b0;
    logic [WIDTH-1:0] m;

    // Marks that at least one edge has passed.
    always_ff @(posedge clk) armed <= 1'b1;

    // Mask as seen at the ports.
    assign m = bus_addr[WIDTH+LSB-1:LSB];

    // R1: reset clears both outputs.
    p_reset_clear_r1: assert property (@(posedge clk)
        (armed && !rst_n) |=> (pin_out == '0 && rd_data == '0));

    // R2: enabled bits take the write data.
    p_masked_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((pin_out & $past(m)) == ($past(wr_data) & $past(m))));

    // R2, R3: disabled bits keep their value.
    p_masked_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (((pin_out ^ $past(pin_out)) & ~$past(m)) == '0));

    // R6: disabled bits read as zero.
    p_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> ((rd_data & ~$past(m)) == '0));

    // R7: read data holds without a read.
    p_read_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R9: no write, no change.
    p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pin_out));
endmodule

bind masked_gpio_reg masked_gpio_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .pin_out  (pin_out)
);

// File: tb/masked_gpio_reg_bench.sv
`timescale 1ns/1ps
module masked_gpio_reg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] bus_addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] wr_data = '0;
    logic [11:0] rd_data;
    logic [11:0] pin_in = '0;
    logic [11:0] pin_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    masked_gpio_reg u_masked_gpio_reg (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en),
        .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data),
        .pin_in(pin_in), .pin_out(pin_out)
    );

    // Write vectors from reset state: {addr, data, expected pin_out}.
    localparam int NV = 9;
    localparam logic [37:0] VEC [NV] = '{
        {14'h3FFC, 12'hA5C, 12'hA5C},  // R4 full write
        {14'h0140, 12'h000, 12'hA0C},  // R2 mask 0x050
        {14'h0000, 12'hFFF, 12'hA0C},  // R3 empty mask
        {14'h2003, 12'h7FF, 12'h20C},  // R5 low bits set, mask 0x800
        {14'h0007, 12'h001, 12'h20D},  // R5 mask bit0 only
        {14'h3FFC, 12'h000, 12'h000},  // R4 full clear
        {14'h1554, 12'hFFF, 12'h555},  // R2 alternate bits
        {14'h2AA8, 12'hFFF, 12'hFFF},  // R2 other half
        {14'h2AA8, 12'h000, 12'h555}   // R2 clear other half
    };

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [13:0] a, input logic [11:0] d);
        @(negedge clk); bus_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [13:0] a);
        @(negedge clk); bus_addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 pin_out after reset", pin_out, 12'h000);
        check("R1 rd_data after reset", rd_data, 12'h000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i][37:24], VEC[i][23:12]);
            check($sformatf("R2 vector %0d", i), pin_out, VEC[i][11:0]);
        end

        // R9: strobe low, full-mask address and data present.
        @(negedge clk); bus_addr = 14'h3FFC; wr_data = 12'hFFF;
        repeat (3) @(negedge clk);
        check("R9 no write without strobe", pin_out, 12'h555);

        // R6: masked reads of settled pins.
        pin_in = 12'hF0F;
        repeat (4) @(negedge clk);
        do_read(14'h3FFC);
        check("R6 full read", rd_data, 12'hF0F);
        do_read(14'h003C);
        check("R6 mask 0x00F", rd_data, 12'h00F);
        do_read(14'h0140);
        check("R6 mask 0x050", rd_data, 12'h000);
        do_read(14'h003F);
        check("R5 read low bits ignored", rd_data, 12'h00F);

        // R7: hold while idle, despite pin, address and write activity.
        pin_in = 12'h0F0; bus_addr = 14'h3FFC;
        do_write(14'h3FFC, 12'h123);
        repeat (3) @(negedge clk);
        check("R7 rd_data held", rd_data, 12'h00F);
        check("R4 write during idle read", pin_out, 12'h123);

        // R8: synchronizer latency.
        pin_in = 12'hF0F;
        repeat (4) @(negedge clk);
        bus_addr = 14'h3FFC; pin_in = 12'h0F0; rd_en = 1'b1;
        @(negedge clk); check("R8 first edge old", rd_data, 12'hF0F);
        @(negedge clk); check("R8 second edge old", rd_data, 12'hF0F);
        @(negedge clk); check("R8 third edge new", rd_data, 12'h0F0);
        rd_en = 1'b0;

        // R1: reset in mid-operation.
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 pin_out mid reset", pin_out, 12'h000);
        check("R1 rd_data mid reset", rd_data, 12'h000);
        rst_n = 1'b1;

        // R3 after reset: empty mask keeps zero.
        do_write(14'h0000, 12'hFFF);
        check("R3 empty mask after reset", pin_out, 12'h000);

        finish_run();
    end
endmodule